// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block watches a bank of already-synchronized GPIO input pins, detects rising and falling transitions on each of them, and turns the detected transitions into one level interrupt per group of sixteen pins. Software chooses, pin by pin, which transitions count. It does so through separate "set" and "clear" registers for the rising mask and for the falling mask, so one pin's enables can change without a read-modify-write of the others.

Every counted transition sets a sticky status bit. Software acknowledges it by writing a one to that bit. Each 32-bit register set serves two interrupt groups: its low half feeds the even group and its high half feeds the odd group. A separate group-enable register gates each group's interrupt line. A status bit keeps latching while its group is gated, so enabling the group later raises the line at once.

The register bus is a simple single-cycle write port with a combinational read port. The block has no state machine: the status, the enables and the edge history are plain registers updated on every clock.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every rising enable, falling enable, status bit and group-enable bit is zero, every read returns zero and every `irq_out` bit is low.
- R2: Register set s starts at byte address 0x10 + 0x20*s and holds pins 32*s to 32*s+31, with pin p at bit p%32. Writing ones to offset 0x00 of the set turns on those pins' rising enables. Writing ones to offset 0x04 turns them off. A read of either offset returns the current rising mask.
- R3: In the same set, writing ones to offset 0x08 turns on the falling enables and writing ones to offset 0x0C turns them off. A read of either offset returns the current falling mask. Zero bits in any of these writes leave their enables unchanged.
- R4: A pin's status bit becomes 1 at the clock edge where the pin is sampled at 1 after being sampled at 0 on the previous edge, if its rising enable was 1 before that edge. A 1-to-0 change does the same under the falling enable. A change with its enable at 0 leaves status unchanged.
- R5: With both enables on, either direction of change latches status.
- R6: Offset 0x10 of a set reads the status bits. Writing a 1 clears that bit and writing a 0 leaves it unchanged.
- R7: If an enabled edge and a clearing write to the same status bit happen at the same clock edge, the bit ends up set.
- R8: Pin p belongs to interrupt group p/16, so group g is taken from the low half (g even) or the high half (g odd) of set g/2.
- R9: The group-enable register at byte address 0x08 has bit g for group g. `irq_out[g]` is high exactly when bit g is 1 and at least one status bit of group g is 1. The line changes in the same cycle as the status or enable register that drives it.
- R10: Status bits latch whether or not their group is enabled.
- R11: Bits of pins at or above NUM_PINS read as zero and ignore writes. Addresses that map to no register read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| bus_we | input | 1 | Write strobe, applied at the clock edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | NUM_GROUPS | One level interrupt per 16-pin group |

## Verification
The edge logic is tried with single-pin pulses under rising-only, falling-only and both-edge masks. These tell a level sensor, a wrong-direction detector and a missing both-edge case apart from the correct behaviour. Pins in the low and high half of each set, plus a set whose high half has no pins, separate a wrong group mapping from a correct one. Clears that collide with edges, status held while its group is disabled, and out-of-range bits and addresses expose wrong priority, wrong gating and stray decode. A long phase of random pin toggles and register writes, compared with a per-pin behavioural model on every clock, catches interactions the directed cases miss.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam logic [7:0] BANK_EN_ADDR = 8'h08;
    localparam logic [7:0] SET_BASE     = 8'h10;
    localparam int         SET_SHIFT    = 5;

    localparam logic [4:0] OFF_RISE_SET = 5'h00;
    localparam logic [4:0] OFF_RISE_CLR = 5'h04;
    localparam logic [4:0] OFF_FALL_SET = 5'h08;
    localparam logic [4:0] OFF_FALL_CLR = 5'h0C;
    localparam logic [4:0] OFF_STATUS   = 5'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BANK_EN,
        SEL_RISE_SET,
        SEL_RISE_CLR,
        SEL_FALL_SET,
        SEL_FALL_CLR,
        SEL_STATUS
    } reg_sel_e;

endpackage

// File: rtl/gpio_edge_decode.sv
module gpio_edge_decode
    import gpio_edge_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_SETS = 2,
    parameter int SIDX_W   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [SIDX_W-1:0] set_idx
);
    localparam int HI_W = ADDR_W - SET_SHIFT;

    logic [ADDR_W-1:0] rel;
    logic [HI_W-1:0]   hi;

    assign rel = addr - ADDR_W'(SET_BASE);
    assign hi  = rel[ADDR_W-1:SET_SHIFT];

    always_comb begin
        sel     = SEL_NONE;
        set_idx = '0;
        if (addr == ADDR_W'(BANK_EN_ADDR)) begin
            sel = SEL_BANK_EN;
        end else if (addr >= ADDR_W'(SET_BASE) && int'(hi) < NUM_SETS) begin
            set_idx = SIDX_W'(hi);
            case (rel[SET_SHIFT-1:0])
                OFF_RISE_SET: sel = SEL_RISE_SET;
                OFF_RISE_CLR: sel = SEL_RISE_CLR;
                OFF_FALL_SET: sel = SEL_FALL_SET;
                OFF_FALL_CLR: sel = SEL_FALL_CLR;
                OFF_STATUS:   sel = SEL_STATUS;
                default:      sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_set.sv
module gpio_edge_set
    import gpio_edge_pkg::*;
#(
    parameter int LIVE_PINS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] pin_in,
    input  logic        wr_en,
    input  reg_sel_e    wr_sel,
    input  logic [31:0] wdata,
    output logic [31:0] rise_en_q,
    output logic [31:0] fall_en_q,
    output logic [31:0] status_q
);
    localparam logic [31:0] LIVE_MASK = 32'((64'd1 << LIVE_PINS) - 64'd1);

    logic [31:0] prev_q;
    logic [31:0] wmask;
    logic [31:0] rise_edge;
    logic [31:0] fall_edge;
    logic [31:0] hit;
    logic [31:0] clr_mask;

    assign wmask     = wdata & LIVE_MASK;
    assign rise_edge = pin_in & ~prev_q & LIVE_MASK;
    assign fall_edge = ~pin_in & prev_q & LIVE_MASK;
    assign hit       = (rise_edge & rise_en_q) | (fall_edge & fall_en_q);
    assign clr_mask  = (wr_en && wr_sel == SEL_STATUS) ? wmask : 32'd0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            status_q  <= '0;
        end else begin
            prev_q   <= pin_in & LIVE_MASK;
            status_q <= (status_q & ~clr_mask) | hit;
            if (wr_en) begin
                case (wr_sel)
                    SEL_RISE_SET: rise_en_q <= rise_en_q | wmask;
                    SEL_RISE_CLR: rise_en_q <= rise_en_q & ~wmask;
                    SEL_FALL_SET: fall_en_q <= fall_en_q | wmask;
                    SEL_FALL_CLR: fall_en_q <= fall_en_q & ~wmask;
                    default: ;
                endcase
            end
        end
    end

    // R2
    rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_RISE_SET) |=>
        ((rise_en_q & $past(wdata & LIVE_MASK)) == $past(wdata & LIVE_MASK)));

    // R3
    fall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_FALL_CLR) |=> ((fall_en_q & $past(wdata)) == 32'd0));

    // R4
    no_spurious_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit)) == 32'd0));

    // R6
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R7
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_STATUS && (hit & wdata) != 32'd0) |=>
        ((status_q & $past(hit & wdata)) == $past(hit & wdata)));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 48,
    parameter int ADDR_W   = 8,
    localparam int NUM_SETS   = (NUM_PINS + 31) / 32,
    localparam int NUM_GROUPS = (NUM_PINS + 15) / 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [NUM_GROUPS-1:0] irq_out
);
    localparam int PAD_W  = NUM_SETS * 32;
    localparam int SIDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

    reg_sel_e              sel;
    logic [SIDX_W-1:0]     set_idx;
    logic [PAD_W-1:0]      pins_pad;
    logic [PAD_W-1:0]      status_flat;
    logic [31:0]           rise_arr   [NUM_SETS];
    logic [31:0]           fall_arr   [NUM_SETS];
    logic [31:0]           status_arr [NUM_SETS];
    logic [NUM_GROUPS-1:0] bank_en_q;

    assign pins_pad = PAD_W'(pin_in);

    gpio_edge_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_SETS (NUM_SETS),
        .SIDX_W   (SIDX_W)
    ) u_decode (
        .addr    (bus_addr),
        .sel     (sel),
        .set_idx (set_idx)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        localparam int LIVE = (NUM_PINS - 32 * s > 32) ? 32 : NUM_PINS - 32 * s;
        logic set_we;
        assign set_we = bus_we && (int'(set_idx) == s);

        gpio_edge_set #(.LIVE_PINS(LIVE)) u_set (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_in    (pins_pad[s*32 +: 32]),
            .wr_en     (set_we),
            .wr_sel    (sel),
            .wdata     (bus_wdata),
            .rise_en_q (rise_arr[s]),
            .fall_en_q (fall_arr[s]),
            .status_q  (status_arr[s])
        );
        assign status_flat[s*32 +: 32] = status_arr[s];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_en_q <= '0;
        end else if (bus_we && sel == SEL_BANK_EN) begin
            bank_en_q <= bus_wdata[NUM_GROUPS-1:0];
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign irq_out[g] = bank_en_q[g] && (|status_flat[g*16 +: 16]);

        // R9
        bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && sel == SEL_BANK_EN && !bus_wdata[g]) |=> !irq_out[g]);
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_BANK_EN:                bus_rdata = 32'(bank_en_q);
            SEL_RISE_SET, SEL_RISE_CLR: bus_rdata = rise_arr[set_idx];
            SEL_FALL_SET, SEL_FALL_CLR: bus_rdata = fall_arr[set_idx];
            SEL_STATUS:                 bus_rdata = status_arr[set_idx];
            default:                    bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
    localparam int NP = 48;
    localparam int NG = (NP + 15) / 16;
    localparam int NS = (NP + 31) / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NG-1:0] irq_out;

    int checks = 0;
    int errors = 0;

    bit          m_rise [NP];
    bit          m_fall [NP];
    bit          m_stat [NP];
    bit          m_prev [NP];
    bit [NG-1:0] m_bank;

    gpio_edge_irq #(.NUM_PINS(NP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #10 clk = ~clk;

    function automatic int reg_off(int p, logic [7:0] a);
        return int'(a) - (16 + 32 * (p / 32));
    endfunction

    // behavioural reference, one pin at a time
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_rise[p] = 0; m_fall[p] = 0; m_stat[p] = 0; m_prev[p] = 0;
            end
            m_bank = '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                bit up, down, hit, clr;
                up   = pin_in[p] && !m_prev[p];
                down = !pin_in[p] && m_prev[p];
                hit  = (up && m_rise[p]) || (down && m_fall[p]);
                clr  = bus_we && bus_wdata[p % 32] && reg_off(p, bus_addr) == 16;
                m_stat[p] = hit || (m_stat[p] && !clr);
                if (bus_we && bus_wdata[p % 32]) begin
                    case (reg_off(p, bus_addr))
                        0:  m_rise[p] = 1;
                        4:  m_rise[p] = 0;
                        8:  m_fall[p] = 1;
                        12: m_fall[p] = 0;
                        default: ;
                    endcase
                end
                m_prev[p] = pin_in[p];
            end
            if (bus_we && bus_addr == 8'h08) m_bank = bus_wdata[NG-1:0];
        end
    end

    function automatic logic [NG-1:0] model_irq();
        logic [NG-1:0] r = '0;
        for (int p = 0; p < NP; p++) if (m_stat[p] && m_bank[p / 16]) r[p / 16] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h08) return 32'(m_bank);
        for (int p = 0; p < NP; p++) begin
            case (reg_off(p, a))
                0, 4:  r[p % 32] = m_rise[p];
                8, 12: r[p % 32] = m_fall[p];
                16:    r[p % 32] = m_stat[p];
                default: ;
            endcase
        end
        return r;
    endfunction

    // R9: every-cycle comparison of the interrupt lines
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            checks++;
            if (irq_out !== model_irq()) begin
                errors++;
                $display("FAIL R9 irq_out actual=%b expected=%b at %0t", irq_out, model_irq(), $time);
            end
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic set_pins(logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic rd_exp(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp || exp !== model_read(a)) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h model=%h", tag, a, bus_rdata, exp, model_read(a));
        end
    endtask

    task automatic irq_exp(logic [NG-1:0] exp, string tag);
        @(negedge clk);
        checks++;
        if (irq_out !== exp) begin
            errors++;
            $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        irq_exp(3'b000, "R1");
        rd_exp(8'h10, 32'h0, "R1");
        rd_exp(8'h20, 32'h0, "R1");
        rd_exp(8'h08, 32'h0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        rd_exp(8'h38, 32'h0, "R1");

        wr(8'h08, 32'h7);
        rd_exp(8'h08, 32'h7, "R9");

        // R2: rising enable via set alias, read through both aliases
        wr(8'h10, 32'h0000_0008);
        rd_exp(8'h10, 32'h8, "R2");
        rd_exp(8'h14, 32'h8, "R2");

        // R4: rising edge on pin 3 latches, falling does not
        set_pins(48'h8);
        rd_exp(8'h20, 32'h8, "R4");
        irq_exp(3'b001, "R8");
        set_pins(48'h0);
        rd_exp(8'h20, 32'h8, "R4");

        // R6: zero write no effect, one write clears
        wr(8'h20, 32'h0);
        rd_exp(8'h20, 32'h8, "R6");
        wr(8'h20, 32'h8);
        rd_exp(8'h20, 32'h0, "R6");
        irq_exp(3'b000, "R6");

        // R3: falling enable on pin 20 (group 1)
        wr(8'h18, 32'h0010_0000);
        rd_exp(8'h1C, 32'h0010_0000, "R3");
        set_pins(48'h10_0000);
        rd_exp(8'h20, 32'h0, "R4");
        set_pins(48'h0);
        rd_exp(8'h20, 32'h0010_0000, "R4");
        irq_exp(3'b010, "R8");

        // R5: both edges on pin 40 (set 1 bit 8, group 2)
        wr(8'h30, 32'h100);
        wr(8'h38, 32'h100);
        set_pins(48'h0100_0000_0000);
        rd_exp(8'h40, 32'h100, "R5");
        wr(8'h40, 32'h100);
        rd_exp(8'h40, 32'h0, "R5");
        set_pins(48'h0);
        rd_exp(8'h40, 32'h100, "R5");
        irq_exp(3'b110, "R8");

        // R10: group 1 disabled, status still latches and holds
        wr(8'h08, 32'h5);
        irq_exp(3'b100, "R10");
        wr(8'h20, 32'h0010_0000);
        set_pins(48'h10_0000);
        set_pins(48'h0);
        rd_exp(8'h20, 32'h0010_0000, "R10");
        irq_exp(3'b100, "R10");
        wr(8'h08, 32'h7);
        irq_exp(3'b110, "R10");

        // R2: clear alias removes rising enable, edge ignored
        wr(8'h14, 32'h8);
        rd_exp(8'h10, 32'h0, "R2");
        set_pins(48'h8);
        rd_exp(8'h20, 32'h0010_0000, "R2");
        set_pins(48'h0);

        // R7: edge and clear on the same clock, edge wins
        wr(8'h10, 32'h8);
        @(negedge clk);
        pin_in = 48'h8; bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h0010_0008;
        @(negedge clk);
        bus_we = 1'b0;
        rd_exp(8'h20, 32'h8, "R7");

        // R11: out-of-range pins and unmapped addresses
        wr(8'h30, 32'hFFFF_FFFF);
        rd_exp(8'h30, 32'h0000_FFFF, "R11");
        wr(8'h34, 32'hFFFF_FEFF);
        rd_exp(8'h34, 32'h0000_0100, "R11");
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        rd_exp(8'h04, 32'h0, "R11");
        rd_exp(8'h50, 32'h0, "R11");
        rd_exp(8'h24, 32'h0, "R11");
        rd_exp(8'h08, 32'h7, "R11");

        // random traffic against the reference
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 2) == 0) pin_in = NP'({$urandom(), $urandom()});
            bus_we = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 6))
                0: bus_addr = 8'h08;
                1: bus_addr = 8'h10 + 8'($urandom_range(0, 4) * 4);
                2: bus_addr = 8'h30 + 8'($urandom_range(0, 4) * 4);
                3: bus_addr = 8'($urandom_range(0, 255));
                default: bus_addr = ($urandom_range(0, 1) == 0) ? 8'h20 : 8'h40;
            endcase
            bus_wdata = $urandom();
            if (bus_addr == 8'h08 && $urandom_range(0, 1) == 0) bus_wdata = 32'h7;
            #1;
            checks++;
            if (bus_rdata !== model_read(bus_addr)) begin
                errors++;
                $display("FAIL R6 random read addr=%h actual=%h expected=%h",
                         bus_addr, bus_rdata, model_read(bus_addr));
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule